// File: doc/BRIEF.md
# SCL Timing Parameter Encoder

This block turns a requested clock divider ratio into the 32-bit word a bus-clock timing register expects. The ratio is the source clock rate divided by the target serial clock rate. On a start strobe the block latches the ratio. It then halves it once per clock until it fits in four bits. Each halving adds one to a power-of-two prescaler exponent. Any bit shifted out is remembered in a sticky round-up flag.

When the ratio fits, the block adds the round-up flag to it. It splits the result into a low-period count and a high-period count, merges them with the exponent and a fixed base pattern, and reports the word with a one-cycle done pulse. A ratio too small to split is reported as an error. A ratio too large for a four-bit exponent saturates to the slowest encodable setting. Control logic loads the word into the timing register once done is seen.

Top module: `scl_timing_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `busy_o`, `done_o` and `error_o` read 0 and `word_o` reads 0.
- R2: A ratio from 2 to 15 needs no halving.
  - The exponent field is 0.
  - The low count is floor(ratio/2)−1.
  - The high count is ratio−low−2.
  - Example: ratio 10 gives 0xFFF44300.
- R3: A ratio of 16 or more is shifted right until it is below 16. The exponent equals the number of shifts. One is added to the reduced ratio when any discarded bit was 1.
  - Example: ratio 100 gives exponent 3 and reduced ratio 13, so the word is 0xFFF65303.
  - Example: ratio 96 gives 0xFFF55303.
- R4: With n halvings, `busy_o` is high for the n+1 cycles after the start edge. `done_o` is high in the cycle after the last busy cycle.
- R5: The result word is 0xFFF00300 OR (high count << 16) OR (low count << 12) OR exponent. The exponent sits in bits 3:0.
- R6: A ratio below 2 is an error.
  - The cycle after the start edge, `done_o` and `error_o` are both 1 and `word_o` is 0xFFF00300.
  - `busy_o` stays 0.
  - A later accepted start with a valid ratio clears `error_o`.
- R7: If 15 halvings still leave the ratio at 16 or more, the result saturates to exponent 15, low 7 and high 7, which is 0xFFF7730F.
  - Example: ratio 2^18 needs exactly 15 halvings and gives 0xFFF3330F.
- R8: While busy, the block ignores a start strobe and any change on `ratio_i`. The result is that of the accepted ratio.
- R9: `done_o` lasts one cycle. `word_o` and `error_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request an encode of `ratio_i` |
| ratio_i | input | 32 | Divider ratio, source rate over target rate |
| busy_o | output | 1 | Halving in progress |
| done_o | output | 1 | One-cycle pulse: `word_o` and `error_o` are fresh |
| error_o | output | 1 | Last accepted ratio was below 2 |
| word_o | output | 32 | Packed timing register value |

## Verification
Small ratios from 2 to 15 check the split arithmetic with no prescaler. Ratios of 16 or more are tried both with and without set bits in the shifted-out positions, which separates a correct sticky round-up from truncation and from always rounding up. Ratios of 0 and 1, the exact 15-halving boundary, and values past it isolate the error path and the saturation path. Random ratios spread across all magnitudes, with start strobes held long or repeated during busy, check latency, the one-cycle done pulse and the rule that starts are ignored while busy.

// File: rtl/scl_enc_pkg.sv
package scl_enc_pkg;

  localparam int CNT_W = 4;
  localparam int RED_W = CNT_W + 1;
  localparam int FIT_LIMIT = 1 << CNT_W;

  localparam logic [31:0] TIMING_BASE = 32'hFFF0_0300;
  localparam int HIGH_LSB = 16;
  localparam int LOW_LSB  = 12;
  localparam int EXP_LSB  = 0;

  typedef enum logic [0:0] {ENC_IDLE, ENC_RUN} enc_state_e;

  // floor(r/2) - 1
  function automatic logic [CNT_W-1:0] low_count(input logic [RED_W-1:0] r);
    logic [RED_W-1:0] t;
    t = (r >> 1) - RED_W'(1);
    return t[CNT_W-1:0];
  endfunction

  // r - low - 2
  function automatic logic [CNT_W-1:0] high_count(input logic [RED_W-1:0] r);
    logic [RED_W-1:0] t;
    t = r - {1'b0, low_count(r)} - RED_W'(2);
    return t[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/scl_ratio_reducer.sv
module scl_ratio_reducer #(
  parameter int RATIO_W = 32,
  parameter int EXP_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load_i,
  input  logic [RATIO_W-1:0]             load_val_i,
  input  logic                           step_i,
  output logic [scl_enc_pkg::CNT_W-1:0]  work_lo_o,
  output logic [EXP_W-1:0]               exp_o,
  output logic                           sticky_o,
  output logic                           fits_o,
  output logic                           at_cap_o
);
  import scl_enc_pkg::*;

  localparam logic [RATIO_W-1:0] LIMIT = RATIO_W'(FIT_LIMIT);

  logic [RATIO_W-1:0] work_q;
  logic [EXP_W-1:0]   exp_q;
  logic               sticky_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q   <= '0;
      exp_q    <= '0;
      sticky_q <= 1'b0;
    end else if (load_i) begin
      work_q   <= load_val_i;
      exp_q    <= '0;
      sticky_q <= 1'b0;
    end else if (step_i) begin
      sticky_q <= sticky_q | work_q[0];
      work_q   <= work_q >> 1;
      exp_q    <= exp_q + EXP_W'(1);
    end
  end

  assign work_lo_o = work_q[CNT_W-1:0];
  assign exp_o     = exp_q;
  assign sticky_o  = sticky_q;
  assign fits_o    = (work_q < LIMIT);
  assign at_cap_o  = &exp_q;

endmodule

// File: rtl/scl_field_packer.sv
module scl_field_packer #(
  parameter int EXP_W = 4
) (
  input  logic [scl_enc_pkg::CNT_W-1:0] work_lo_i,
  input  logic                          sticky_i,
  input  logic                          sat_i,
  input  logic [EXP_W-1:0]              exp_i,
  output logic [31:0]                   word_o
);
  import scl_enc_pkg::*;

  logic [RED_W-1:0] reduced;
  logic [CNT_W-1:0] lo_cnt;
  logic [CNT_W-1:0] hi_cnt;

  always_comb begin
    if (sat_i) reduced = RED_W'(FIT_LIMIT);
    else       reduced = {1'b0, work_lo_i} + RED_W'(sticky_i);
    lo_cnt = low_count(reduced);
    hi_cnt = high_count(reduced);
    word_o = TIMING_BASE
           | (32'(hi_cnt) << HIGH_LSB)
           | (32'(lo_cnt) << LOW_LSB)
           | (32'(exp_i)  << EXP_LSB);
  end

endmodule

// File: rtl/scl_timing_encoder.sv
module scl_timing_encoder #(
  parameter int RATIO_W = 32,
  parameter int EXP_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o,
  output logic [31:0]        word_o
);
  import scl_enc_pkg::*;

  enc_state_e state_q;

  logic [CNT_W-1:0] work_lo;
  logic [EXP_W-1:0] exp_w;
  logic             sticky_w;
  logic             fits_w;
  logic             at_cap_w;
  logic [31:0]      packed_w;

  // named internal events
  logic accept_w;
  logic too_small_w;
  logic load_w;
  logic step_w;
  logic finish_w;
  logic sat_w;

  assign accept_w    = start_i && (state_q == ENC_IDLE);
  assign too_small_w = (ratio_i < RATIO_W'(2));
  assign load_w      = accept_w && !too_small_w;
  assign step_w      = (state_q == ENC_RUN) && !fits_w && !at_cap_w;
  assign finish_w    = (state_q == ENC_RUN) && !step_w;
  assign sat_w       = !fits_w;

  scl_ratio_reducer #(.RATIO_W(RATIO_W), .EXP_W(EXP_W)) reducer_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_w),
    .load_val_i (ratio_i),
    .step_i     (step_w),
    .work_lo_o  (work_lo),
    .exp_o      (exp_w),
    .sticky_o   (sticky_w),
    .fits_o     (fits_w),
    .at_cap_o   (at_cap_w)
  );

  scl_field_packer #(.EXP_W(EXP_W)) packer_i (
    .work_lo_i (work_lo),
    .sticky_i  (sticky_w),
    .sat_i     (sat_w),
    .exp_i     (exp_w),
    .word_o    (packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENC_IDLE;
      done_o  <= 1'b0;
      error_o <= 1'b0;
      word_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_w) begin
        if (too_small_w) begin
          error_o <= 1'b1;
          word_o  <= TIMING_BASE;
          done_o  <= 1'b1;
        end else begin
          error_o <= 1'b0;
          state_q <= ENC_RUN;
        end
      end
      if (finish_w) begin
        state_q <= ENC_IDLE;
        word_o  <= packed_w;
        done_o  <= 1'b1;
      end
    end
  end

  assign busy_o = (state_q == ENC_RUN);

endmodule

// File: rtl/scl_timing_encoder_chk.sv
module scl_timing_encoder_chk #(
  parameter int RATIO_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               error_o,
  input logic [31:0]        word_o,
  input logic               finish_w
);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> !done_o);

  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  a_r4_finish_done: assert property (@(posedge clk) disable iff (rst)
    finish_w |=> (done_o && !busy_o));

  a_r6_error_base: assert property (@(posedge clk) disable iff (rst)
    error_o |-> (word_o == 32'hFFF0_0300));

  a_r6_small_flags: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (ratio_i < RATIO_W'(2))) |=> (done_o && error_o && !busy_o));

  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    (done_o && !error_o) |-> ((word_o[31:20] == 12'hFFF) && (word_o[11:4] == 8'h30)));

  a_r2_balance: assert property (@(posedge clk) disable iff (rst)
    (done_o && !error_o) |->
      ((word_o[19:16] == word_o[15:12]) || (word_o[19:16] == word_o[15:12] + 4'd1)));

  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !finish_w) |=> busy_o);

endmodule

bind scl_timing_encoder scl_timing_encoder_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .ratio_i  (ratio_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .error_o  (error_o),
  .word_o   (word_o),
  .finish_w (finish_w)
);

// File: tb/scl_timing_encoder_tb.sv
module scl_timing_encoder_tb_top;

  localparam time HALF = 2ns;   // 250 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] ratio_i = '0;
  logic        busy_o, done_o, error_o;
  logic [31:0] word_o;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #(HALF) clk = ~clk;

  scl_timing_encoder dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .ratio_i(ratio_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .word_o(word_o)
  );

  // reference arithmetic, stated from the requirements
  task automatic ref_calc(input logic [31:0] r, output logic [31:0] w,
                          output bit err, output int nh);
    longint rr, red, lo, hi, mask;
    rr = longint'(r);
    err = 0;
    nh = 0;
    if (rr < 2) begin
      err = 1;
      w = 32'hFFF0_0300;
      return;
    end
    while ((rr >> nh) >= 16) nh++;
    if (nh > 15) begin
      nh = 15;
      red = 16;
    end else begin
      mask = (longint'(1) << nh) - 1;
      red = (rr >> nh) + (((rr & mask) != 0) ? 1 : 0);
    end
    lo = red / 2 - 1;
    hi = red - lo - 2;
    w = 32'hFFF0_0300 | 32'(hi << 16) | 32'(lo << 12) | 32'(nh);
  endtask

  // cycle-level behavioural model
  bit          m_busy, m_done, m_err;
  logic [31:0] m_word, p_word;
  int          m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_word = '0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          m_done = 1;
          m_word = p_word;
        end
      end else if (start_i) begin
        logic [31:0] w;
        bit e;
        int n;
        ref_calc(ratio_i, w, e, n);
        if (e) begin
          m_err = 1; m_done = 1; m_word = w;
        end else begin
          m_err = 0; m_busy = 1; m_cnt = n + 1; p_word = w;
        end
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (busy_o !== m_busy || done_o !== m_done || error_o !== m_err || word_o !== m_word) begin
      miscompares++;
      $display("FAIL %s cycle compare: busy/done/err/word got %b/%b/%b/%h exp %b/%b/%b/%h",
               cur_req, busy_o, done_o, error_o, word_o, m_busy, m_done, m_err, m_word);
    end
  end

  task automatic expect_eq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // single request; returns negedges until done and the word seen then
  task automatic run_one(input logic [31:0] r, output int lat, output logic [31:0] w);
    @(negedge clk);
    start_i = 1'b1;
    ratio_i = r;
    lat = 0;
    w = 'x;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      ratio_i = $urandom();
      lat++;
      if (done_o) begin
        w = word_o;
        break;
      end
    end
  endtask

  task automatic word_case(input string tag, input logic [31:0] r, input logic [31:0] exp);
    int lat;
    logic [31:0] w;
    cur_req = tag;
    run_one(r, lat, w);
    expect_eq(tag, w, exp);
  endtask

  initial begin
    int lat;
    logic [31:0] w;

    repeat (3) @(negedge clk);
    cur_req = "R1";
    expect_eq("R1 reset busy/done/err", {29'd0, busy_o, done_o, error_o}, 32'd0);
    expect_eq("R1 reset word", word_o, 32'd0);
    rst = 1'b0;

    word_case("R2 ratio 10", 32'd10, 32'hFFF44300);
    word_case("R2 ratio 15", 32'd15, 32'hFFF76300);
    word_case("R2 ratio 3",  32'd3,  32'hFFF10300);
    word_case("R2 ratio 2",  32'd2,  32'hFFF00300);
    expect_eq("R2 ratio 2 no error", {31'd0, error_o}, 32'd0);

    word_case("R3 ratio 100 round-up", 32'd100, 32'hFFF65303);
    word_case("R3 ratio 96 exact",     32'd96,  32'hFFF55303);
    word_case("R3 ratio 16",           32'd16,  32'hFFF33301);
    word_case("R5 ratio 31 to 16",     32'd31,  32'hFFF77301);

    cur_req = "R4";
    run_one(32'd100, lat, w);
    expect_eq("R4 latency ratio 100", 32'(lat), 32'd5);
    run_one(32'd10, lat, w);
    expect_eq("R4 latency ratio 10", 32'(lat), 32'd2);

    word_case("R6 ratio 0", 32'd0, 32'hFFF00300);
    expect_eq("R6 error set", {31'd0, error_o}, 32'd1);
    cur_req = "R6";
    run_one(32'd1, lat, w);
    expect_eq("R6 ratio 1 latency", 32'(lat), 32'd1);
    expect_eq("R6 ratio 1 error", {31'd0, error_o}, 32'd1);
    word_case("R6 cleared by valid", 32'd10, 32'hFFF44300);
    expect_eq("R6 error cleared", {31'd0, error_o}, 32'd0);

    word_case("R7 2^19 saturate",  32'h0008_0000, 32'hFFF7730F);
    word_case("R7 all ones",       32'hFFFF_FFFF, 32'hFFF7730F);
    word_case("R7 2^19-1",         32'h0007_FFFF, 32'hFFF7730F);
    word_case("R7 2^18 boundary",  32'h0004_0000, 32'hFFF3330F);

    // R8: start strobes during busy ignored
    cur_req = "R8";
    @(negedge clk);
    start_i = 1'b1; ratio_i = 32'd100;
    @(negedge clk);
    start_i = 1'b1; ratio_i = 32'd5;
    @(negedge clk);
    start_i = 1'b1; ratio_i = 32'd0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 10 && !done_o; i++) @(negedge clk);
    expect_eq("R8 busy start ignored", word_o, 32'hFFF65303);

    // R9: single-cycle done, word held
    cur_req = "R9";
    @(negedge clk);
    expect_eq("R9 done dropped", {31'd0, done_o}, 32'd0);
    expect_eq("R9 word held", word_o, 32'hFFF65303);

    // random sweep; the per-cycle model checks everything
    cur_req = "R3 random";
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      start_i = 1'b1;
      ratio_i = $urandom() >> ($urandom() % 32);
      repeat ($urandom() % 3) @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
      repeat ($urandom() % 20) @(negedge clk);
    end
    repeat (25) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(HALF * 2 * 150000);
    miscompares++;
    $display("FAIL watchdog expired during %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule